// File: doc/BRIEF.md
# Hierarchical Instrument Status Register Array

This block is the status subsystem of a measurement instrument. It follows the layered status arrangement of IEEE-488.2. Two groups of live inputs feed it. Level conditions report input overload, the upper and lower limit and idle. Single-cycle event pulses come from two sources: the standard command and operation engine, and the communication channel.

Each event pulse sets a sticky bit in one of two event registers. A sticky bit is cleared only when software reads that register. Each event register has an enable mask. When an event bit and its enable bit are both 1, a summary bit in the status byte is set. The status byte has its own service-request enable. That enable selects which status-byte bits drive the master summary bit, and the master summary bit drives the service-request output.

Software reaches all registers through a small bus. The bus has a write strobe, a read strobe, a 3-bit address and 8-bit data. Read data is combinational and is valid in the cycle of the read strobe. The clear caused by a read takes effect at the clock edge that ends that cycle.

Top module: `instr_status_array`

## Requirements
- R1: Address 6 returns the live levels {idle, lower limit, upper limit, overload} in bits 3..0, with bits 7..4 at 0. Status-byte bits 0, 1, 2 and 4 are overload, upper limit, lower limit and idle, taken live from cond_i bits 0..3. Reading address 6 or address 0 changes no stored state.
- R2: A pulse on std_evt_i[i] sets bit i of the standard event register (address 2). A pulse on com_evt_i[i] sets bit i of the communication event register (address 4). A set bit stays 1 until that register is read.
- R3: A read of address 2 or address 4 returns the register's contents in the same cycle. Every bit that was set is cleared at the following clock edge.
- R4: If an event pulse arrives in the same cycle as a read of its register, the bit for that pulse is 1 after the clear.
- R5: Status-byte bit 5 is 1 exactly when standard event AND standard enable (address 3) is non-zero. Status-byte bit 7 is 1 exactly when communication event AND communication enable (address 5) is non-zero.
- R6: Status-byte bit 6 is 1 exactly when the status byte AND the service-request enable (address 1) is non-zero, taken over bits other than 6. Bit 6 of the service-request enable has no effect. srq_o equals status-byte bit 6.
- R7: Status-byte bit 3 always reads 0. Writes to addresses 0, 2, 4 and 6 change nothing. Reads of address 7 return 0.
- R8: Addresses 1, 3 and 5 hold the 8-bit value last written to them and read it back.
- R9: After reset, the standard event register is 0x80 (power-on, bit 7), the communication event register is 0, and all three enable registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| std_evt_i | input | 8 | Standard event pulses, bit i sets event bit i |
| com_evt_i | input | 8 | Communication error pulses, bit i sets event bit i |
| cond_i | input | 4 | Live levels {idle, lower limit, upper limit, overload} |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 3 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when rd_en is low |
| srq_o | output | 1 | Service request, equals master summary |

## Verification
The hardest case to reach is a pulse that lands in the same cycle as the read that clears its register. Both must also occur while the enables make the resulting summary and service-request change visible. The random stimulus sets pulses sparsely and reads often, so these collisions happen many times. Directed steps then force a collision with only one bit pulsed and every enable open, and check that the bit and srq_o survive the clear. A further directed step sets only bit 6 of the service-request enable, to show that this bit has no effect.

// File: rtl/stat_pkg.sv
package stat_pkg;
    localparam int REG_W  = 8;
    localparam int ADDR_W = 3;
    localparam int COND_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_STB = 3'd0,
        A_SRE = 3'd1,
        A_SEV = 3'd2,
        A_SEN = 3'd3,
        A_CEV = 3'd4,
        A_CEN = 3'd5,
        A_CND = 3'd6,
        A_NUL = 3'd7
    } reg_addr_e;

    // status byte bit positions
    localparam int SB_OVLD = 0;
    localparam int SB_ULIM = 1;
    localparam int SB_LLIM = 2;
    localparam int SB_UNDF = 3;
    localparam int SB_IDLE = 4;
    localparam int SB_ESB  = 5;
    localparam int SB_MSS  = 6;
    localparam int SB_CESB = 7;

    localparam logic [REG_W-1:0] STD_RST = 8'h80;
    localparam logic [REG_W-1:0] COM_RST = 8'h00;
endpackage

// File: rtl/stat_evt_bank.sv
module stat_evt_bank #(
    parameter int W = 8,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pulse_i,
    input  logic         rd_clr_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] evt_o,
    output logic [W-1:0] mask_o,
    output logic         sum_o
);
    typedef struct packed {
        logic [W-1:0] evt;
        logic [W-1:0] mask;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_clr_i) begin
            st_d.evt = '0;
        end
        st_d.evt = st_d.evt | pulse_i;
        if (wr_i) begin
            st_d.mask = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.evt  <= RST_VAL;
            st_q.mask <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign evt_o  = st_q.evt;
    assign mask_o = st_q.mask;
    assign sum_o  = |(st_q.evt & st_q.mask);

    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_clr_i |=> ((evt_o & $past(evt_o)) == $past(evt_o))); // R2
    AST_CLEAR_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_clr_i && pulse_i == '0) |=> (evt_o == '0)); // R3
    AST_PULSE_SURVIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (pulse_i != '0) |=> ((evt_o & $past(pulse_i)) == $past(pulse_i))); // R4
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_i |=> $stable(mask_o)); // R8
endmodule

// File: rtl/stat_byte_sum.sv
module stat_byte_sum
    import stat_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic [COND_W-1:0] cond_i,
    input  logic              esb_i,
    input  logic              cesb_i,
    output logic [REG_W-1:0]  stb_o,
    output logic [REG_W-1:0]  sre_o,
    output logic              mss_o
);
    typedef struct packed {
        logic [REG_W-1:0] sre;
    } sb_t;

    sb_t st_d, st_q;
    logic [REG_W-1:0] base;
    localparam logic [REG_W-1:0] MSS_KEEP = ~(REG_W'(1) << SB_MSS);

    always_comb begin
        st_d = st_q;
        if (wr_i) begin
            st_d.sre = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sre <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        base          = '0;
        base[SB_OVLD] = cond_i[0];
        base[SB_ULIM] = cond_i[1];
        base[SB_LLIM] = cond_i[2];
        base[SB_IDLE] = cond_i[3];
        base[SB_ESB]  = esb_i;
        base[SB_CESB] = cesb_i;
        mss_o         = |(base & st_q.sre & MSS_KEEP);
        stb_o         = base;
        stb_o[SB_MSS] = mss_o;
    end

    assign sre_o = st_q.sre;

    AST_UNDEF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        stb_o[SB_UNDF] == 1'b0); // R7
    AST_MSS_SOURCED: assert property (@(posedge clk) disable iff (!rst_n)
        mss_o |-> ((stb_o & sre_o & MSS_KEEP) != '0)); // R6
endmodule

// File: rtl/instr_status_array.sv
module instr_status_array
    import stat_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  std_evt_i,
    input  logic [7:0]  com_evt_i,
    input  logic [3:0]  cond_i,
    input  logic        wr_en,
    input  logic        rd_en,
    input  logic [2:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    output logic        srq_o
);
    logic [REG_W-1:0] std_evt, std_msk, com_evt, com_msk, stb, sre;
    logic std_sum, com_sum, mss;
    logic rd_std, rd_com, wr_sre, wr_sen, wr_cen;

    always_comb begin
        rd_std = rd_en && (addr == A_SEV);
        rd_com = rd_en && (addr == A_CEV);
        wr_sre = wr_en && (addr == A_SRE);
        wr_sen = wr_en && (addr == A_SEN);
        wr_cen = wr_en && (addr == A_CEN);
    end

    stat_evt_bank #(.W(REG_W), .RST_VAL(STD_RST)) u_std (
        .clk(clk), .rst_n(rst_n), .pulse_i(std_evt_i), .rd_clr_i(rd_std),
        .wr_i(wr_sen), .wdata_i(wdata), .evt_o(std_evt), .mask_o(std_msk),
        .sum_o(std_sum));

    stat_evt_bank #(.W(REG_W), .RST_VAL(COM_RST)) u_com (
        .clk(clk), .rst_n(rst_n), .pulse_i(com_evt_i), .rd_clr_i(rd_com),
        .wr_i(wr_cen), .wdata_i(wdata), .evt_o(com_evt), .mask_o(com_msk),
        .sum_o(com_sum));

    stat_byte_sum u_sb (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_sre), .wdata_i(wdata),
        .cond_i(cond_i), .esb_i(std_sum), .cesb_i(com_sum),
        .stb_o(stb), .sre_o(sre), .mss_o(mss));

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (reg_addr_e'(addr))
                A_STB:   rdata = stb;
                A_SRE:   rdata = sre;
                A_SEV:   rdata = std_evt;
                A_SEN:   rdata = std_msk;
                A_CEV:   rdata = com_evt;
                A_CEN:   rdata = com_msk;
                A_CND:   rdata = {{(REG_W-COND_W){1'b0}}, cond_i};
                default: rdata = '0;
            endcase
        end
    end

    assign srq_o = mss;

    AST_PASSIVE_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !wr_en && (addr == A_CND || addr == A_STB) &&
         std_evt_i == '0 && com_evt_i == '0)
        |=> ($stable(std_evt) && $stable(com_evt))); // R1
    AST_RO_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr[0] == 1'b0) |=> ($stable(sre) && $stable(std_msk) && $stable(com_msk))); // R7
    AST_ESB_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        stb[SB_ESB] == ((std_evt & std_msk) != '0)); // R5
endmodule

// File: tb/instr_status_array_test.sv
module instr_status_array_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] std_evt_i = '0, com_evt_i = '0, wdata = '0;
    logic [3:0] cond_i = '0;
    logic wr_en = 1'b0, rd_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] rdata;
    logic srq_o;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // bench model state
    logic [7:0] m_std, m_com, m_sen, m_cen, m_sre;

    always #2 clk = ~clk;

    instr_status_array uut (
        .clk(clk), .rst_n(rst_n), .std_evt_i(std_evt_i), .com_evt_i(com_evt_i),
        .cond_i(cond_i), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .srq_o(srq_o));

    function automatic logic [7:0] f_stb(input logic [7:0] s, sen, c, cen, sre,
                                         input logic [3:0] cnd);
        logic [7:0] b;
        b = {((c & cen) != 0), 1'b0, ((s & sen) != 0), cnd[3], 1'b0, cnd[2], cnd[1], cnd[0]};
        b[6] = ((b & sre & 8'hBF) != 0);
        return b;
    endfunction

    function automatic logic [7:0] f_read(input logic [2:0] a);
        logic [7:0] sb;
        sb = f_stb(m_std, m_sen, m_com, m_cen, m_sre, cond_i);
        case (a)
            3'd0: return sb;
            3'd1: return m_sre;
            3'd2: return m_std;
            3'd3: return m_sen;
            3'd4: return m_com;
            3'd5: return m_cen;
            3'd6: return {4'h0, cond_i};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input logic [7:0] act, input logic [7:0] exp, input string tag);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string tag_for(input logic [2:0] a);
        case (a)
            3'd0: return "R6 status byte";
            3'd2, 3'd4: return "R3 event read";
            3'd6: return "R1 condition";
            3'd7: return "R7 null address";
            default: return "R8 enable";
        endcase
    endfunction

    // drive one cycle: inputs after negedge, check, update model after posedge
    task automatic step(input logic [7:0] se, ce, input logic [3:0] cn,
                        input logic w, r, input logic [2:0] a, input logic [7:0] wd);
        logic [7:0] sb;
        @(negedge clk);
        std_evt_i = se; com_evt_i = ce; cond_i = cn;
        wr_en = w; rd_en = r; addr = a; wdata = wd;
        #1;
        sb = f_stb(m_std, m_sen, m_com, m_cen, m_sre, cond_i);
        check({7'b0, srq_o}, {7'b0, sb[6]}, "R6 srq");
        if (r) check(rdata, f_read(a), tag_for(a));
        else   check(rdata, 8'h00, "R7 idle bus");
        @(posedge clk);
        #0;
        if (r && a == 3'd2) m_std = 8'h00;
        if (r && a == 3'd4) m_com = 8'h00;
        m_std = m_std | se;
        m_com = m_com | ce;
        if (w && a == 3'd1) m_sre = wd;
        if (w && a == 3'd3) m_sen = wd;
        if (w && a == 3'd5) m_cen = wd;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd5150));
        m_std = 8'h80; m_com = 0; m_sen = 0; m_cen = 0; m_sre = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: reset values
        step(0, 0, 0, 0, 1, 3'd2, 0);   // R9 std event reads 0x80 (then clears)
        check(m_std, 8'h00, "R9 model sanity");
        step(0, 0, 0, 0, 1, 3'd4, 0);   // R9 comm 0
        step(0, 0, 0, 0, 1, 3'd1, 0);   // R9 sre 0
        step(0, 0, 0, 0, 1, 3'd3, 0);
        step(0, 0, 0, 0, 1, 3'd5, 0);

        // R8 enable write/readback, R7 write to read-only ignored
        step(0, 0, 0, 1, 0, 3'd3, 8'hFF);
        step(0, 0, 0, 1, 0, 3'd5, 8'hFF);
        step(0, 0, 0, 1, 0, 3'd2, 8'hFF);   // R7 ignored
        step(0, 0, 0, 0, 1, 3'd2, 0);       // expect 0
        // R6: only bit 6 of sre set -> no request
        step(0, 0, 0, 1, 0, 3'd1, 8'h40);
        step(8'h01, 0, 4'hF, 0, 1, 3'd0, 0); // conditions active, sre bit6 only
        // R4: pulse colliding with clear
        step(0, 0, 0, 1, 0, 3'd1, 8'hA0);
        step(8'h10, 0, 0, 0, 1, 3'd2, 0);    // R4 read returns 01, pulse 10 stays
        step(0, 0, 0, 0, 1, 3'd2, 0);        // R4 expect 10
        step(0, 8'h04, 0, 0, 1, 3'd4, 0);    // R4 comm collision
        step(0, 0, 0, 0, 1, 3'd0, 0);        // R5 CESB visible, srq high
        step(0, 0, 0, 0, 1, 3'd4, 0);
        // R1 live conditions, R2 sticky after pulse ends
        step(8'h22, 0, 4'h5, 0, 1, 3'd6, 0);
        step(0, 0, 4'hA, 0, 1, 3'd6, 0);
        step(0, 0, 4'hA, 0, 1, 3'd2, 0);     // R2 expect 22

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            logic [7:0] se, ce, wd;
            logic [3:0] cn;
            logic w, r;
            logic [2:0] a;
            se = 8'($urandom & $urandom & $urandom & $urandom);
            ce = 8'($urandom & $urandom & $urandom & $urandom);
            cn = 4'($urandom);
            w  = ($urandom % 5) == 0;
            r  = ($urandom % 2) == 0;
            a  = 3'($urandom);
            wd = 8'($urandom);
            step(se, ce, cn, w, r, a, wd);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule